// File: doc/BRIEF.md
# Byte-Framed Serial Configuration Port

This block is the device side of a three-wire configuration link for a radio. A host raises a select line, toggles a serial clock and moves bits over one shared data line. The port brings all three pins into its own clock domain. On each rising edge of the serial clock it acts on the level of the data line. When select drops, the port returns to its idle framing state.

The first byte of every select window is a command. Bit 7 gives the direction: 1 means read and 0 means write. Bits 6:0 give a starting register address. In a write, every following byte goes into the addressed control register as soon as its eighth bit has arrived, and the address then advances by one. Select does not have to fall for a byte to take effect. In a read, the port drives the data line for the rest of the window. It presents the addressed register most significant bit first and changes bit on each rising edge, so the host can sample on falling edges. After every byte the address advances. Addresses are 7 bits wide and wrap from 127 to 0. Only the lowest `NREGS` addresses hold storage.

Top module: `cfgport`

## Requirements
- R1: After reset every control register reads 0x00, and both `cfg_sdo_oe` and `cfg_sdo` are low.
- R2: A command byte with bit 7 = 0 and address A, followed by byte D, stores D into register A. Bits are taken most significant first, one per serial-clock rising edge.
- R3: A written byte becomes visible on `regs_o` once its eighth rising edge has been processed, while select is still high.
- R4: Further data bytes in the same write window go to A+1, A+2 and so on.
- R5: When select falls, any partial byte is discarded and no register changes. The next window starts again with a command byte.
- R6: A command byte with bit 7 = 1 makes the port drive `cfg_sdo_oe` high and shift out register A, most significant first. Each bit is updated after a rising edge and holds steady through the following falling edge.
- R7: A read window continues with registers A+1, A+2 and so on, for as many bytes as the host clocks.
- R8: `cfg_sdo_oe` is low during command bytes, during write windows and whenever select is low. `cfg_sdo` is low whenever `cfg_sdo_oe` is low.
- R9: Serial-clock and data activity while select is low has no effect on any register.
- R10: Writes to an address at or above `NREGS` change no register, and reads from such an address return 0x00.
- R11: The address advances modulo 128, so a burst that passes address 127 continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; must run well above the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | Select; transfers happen only while high |
| cfg_sclk | input | 1 | Serial clock from the host |
| cfg_sdi | input | 1 | Data line level as seen by the port |
| cfg_sdo | output | 1 | Data the port drives during reads |
| cfg_sdo_oe | output | 1 | High while the port owns the data line |
| regs_o | output | NREGS*8 | Control register contents, register i in bits 8i+7:8i |

## Verification
Each pin passes through `SYNC_STAGES` flops, which is two by default, so a rising edge of the serial clock is recognised on the second clock after it. `cfg_sdo` and `cfg_sdo_oe` then update on the third clock, and a completed byte reaches `regs_o` on the fourth. The bench holds each serial-clock phase for eight clocks. It reads the data line only at falling edges, which is where the host samples. It compares `regs_o` with its own model only after the falling edge that ends a byte. Every result is therefore due at least four clocks before the bench looks, and select is still high when register contents are checked.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = BYTE_W - 1;

   typedef enum logic [1:0] {
      PH_CMD   = 2'd0,
      PH_WRITE = 2'd1,
      PH_READ  = 2'd2
   } phase_e;
endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("cfgport_sync: STAGES must be at least 1");
      end
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         if (STAGES == 1) begin : g_single
            logic flop;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) flop <= 1'b0;
               else        flop <= d[b];
            end
            assign q[b] = flop;
         end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain <= '0;
               else        chain <= {chain[STAGES-2:0], d[b]};
            end
            assign q[b] = chain[STAGES-1];
         end
      end
   endgenerate
endmodule

// File: rtl/cfgport_frame.sv
module cfgport_frame
   import cfgport_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_s,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              sdo,
   output logic              sdo_oe
);
   localparam int CNT_W = $clog2(BYTE_W);

   phase_e            phase_q;
   logic              sclk_d;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-2:0] rx_q;
   logic [BYTE_W-1:0] tx_q;
   logic [ADDR_W-1:0] addr_q;
   logic              oe_q;

   logic              rise;
   logic              last_bit;
   logic [BYTE_W-1:0] byte_now;
   logic [ADDR_W-1:0] addr_inc;

   assign rise     = sel_s & sclk_s & ~sclk_d;
   assign last_bit = (cnt_q == CNT_W'(BYTE_W - 1));
   assign byte_now = {rx_q, sdi_s};
   assign addr_inc = addr_q + 1'b1;
   assign rd_addr  = (phase_q == PH_CMD) ? byte_now[ADDR_W-1:0] : addr_inc;
   assign sdo_oe   = oe_q;
   assign sdo      = oe_q & tx_q[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_CMD;
         sclk_d  <= 1'b0;
         cnt_q   <= '0;
         rx_q    <= '0;
         tx_q    <= '0;
         addr_q  <= '0;
         oe_q    <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         sclk_d <= sclk_s;
         wr_en  <= 1'b0;
         if (!sel_s) begin
            phase_q <= PH_CMD;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
         end else if (rise) begin
            cnt_q <= cnt_q + 1'b1;
            rx_q  <= byte_now[BYTE_W-2:0];
            case (phase_q)
               PH_CMD: begin
                  if (last_bit) begin
                     addr_q <= byte_now[ADDR_W-1:0];
                     if (byte_now[BYTE_W-1]) begin
                        phase_q <= PH_READ;
                        oe_q    <= 1'b1;
                        tx_q    <= rd_data;
                     end else begin
                        phase_q <= PH_WRITE;
                     end
                  end
               end
               PH_WRITE: begin
                  if (last_bit) begin
                     wr_en   <= 1'b1;
                     wr_addr <= addr_q;
                     wr_data <= byte_now;
                     addr_q  <= addr_inc;
                  end
               end
               PH_READ: begin
                  if (last_bit) begin
                     addr_q <= addr_inc;
                     tx_q   <= rd_data;
                  end else begin
                     tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                  end
               end
               default: phase_q <= PH_CMD;
            endcase
         end
      end
   end

   // R8: the data line is released on the cycle after select is seen low
   assert_release_on_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_s |=> !sdo_oe);
   // R8: the port drives the line only in the read phase
   assert_drive_only_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> (phase_q == PH_READ));
   // R6: the output bit holds between recognised rising edges
   assert_sdo_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise && sel_s) |=> $stable(tx_q));
   // R3: one commit per byte, never on two adjacent cycles
   assert_single_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);
endmodule

// File: rtl/cfgport_regbank.sv
module cfgport_regbank
   import cfgport_pkg::*;
#(
   parameter int NREGS = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [BYTE_W-1:0]       wr_data,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [BYTE_W-1:0]       rd_data,
   output logic [NREGS*BYTE_W-1:0] regs_o
);
   generate
      for (genvar g = 0; g < NREGS; g++) begin : g_reg
         logic [BYTE_W-1:0] val;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    val <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))       val <= wr_data;
         end
         assign regs_o[g*BYTE_W +: BYTE_W] = val;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREGS; i++) begin
         if (rd_addr == ADDR_W'(i)) rd_data = regs_o[i*BYTE_W +: BYTE_W];
      end
   end

   // R10: a commit beyond the populated range leaves the bank untouched
   assert_oob_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) >= NREGS) |=> $stable(regs_o));
endmodule

// File: rtl/cfgport.sv
module cfgport
   import cfgport_pkg::*;
#(
   parameter int NREGS       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_sel,
   input  logic                    cfg_sclk,
   input  logic                    cfg_sdi,
   output logic                    cfg_sdo,
   output logic                    cfg_sdo_oe,
   output logic [NREGS*BYTE_W-1:0] regs_o
);
   generate
      if (NREGS < 1 || NREGS > (1 << ADDR_W)) begin : g_bad_nregs
         $error("cfgport: NREGS must lie between 1 and 128");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic [ADDR_W-1:0] rd_addr;
   logic [BYTE_W-1:0] rd_data;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [BYTE_W-1:0] wr_data;

   cfgport_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cfg_sel, cfg_sclk, cfg_sdi}),
      .q     (pins_s)
   );

   cfgport_frame u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_s   (pins_s[2]),
      .sclk_s  (pins_s[1]),
      .sdi_s   (pins_s[0]),
      .rd_data (rd_data),
      .rd_addr (rd_addr),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sdo     (cfg_sdo),
      .sdo_oe  (cfg_sdo_oe)
   );

   cfgport_regbank #(.NREGS(NREGS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .regs_o  (regs_o)
   );

   // R9: with select low at the pins for the whole pipeline, the bank stays put
   assert_idle_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pins_s[2] && !wr_en) |=> $stable(regs_o));
endmodule

// File: tb/cfgport_tb.sv
module cfgport_tb;
   localparam int NR = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, sel, sclk, sdi;
   logic sdo, sdo_oe;
   logic [NR*8-1:0] regs;

   cfgport #(.NREGS(NR), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_sel(sel), .cfg_sclk(sclk), .cfg_sdi(sdi),
      .cfg_sdo(sdo), .cfg_sdo_oe(sdo_oe), .regs_o(regs)
   );

   int checks = 0;
   int errors = 0;
   logic [7:0] model [NR];
   logic [7:0] exp_q [$];
   logic [7:0] mon_sh;
   int mon_n = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      sdi = b; tick(8);
      sclk = 1'b1; tick(8);
      sclk = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic open_win();  sel = 1'b1; tick(8); endtask
   task automatic close_win(); tick(8); sel = 1'b0; tick(8); endtask

   task automatic check_bank(input string req);
      for (int i = 0; i < NR; i++)
         check(regs[i*8 +: 8] == model[i], req, $sformatf("reg%0d", i),
               int'(regs[i*8 +: 8]), int'(model[i]));
   endtask

   // driver: write burst; the model is updated, and the bank is compared with it after each byte
   task automatic write_burst(input logic [6:0] a, input logic [7:0] d [$], input string req);
      logic [6:0] ad = a;
      open_win();
      send_byte({1'b0, a});
      check(!sdo_oe, "R8", "oe after write command", int'(sdo_oe), 0);
      foreach (d[k]) begin
         send_byte(d[k]);
         if (int'(ad) < NR) model[ad] = d[k];
         ad = ad + 7'd1;
         check(!sdo_oe, "R8", "oe during write data", int'(sdo_oe), 0);
         check_bank(req); // R3: checked before select falls
      end
      close_win();
   endtask

   // driver: read burst; expected bytes go into the scoreboard queue
   task automatic read_burst(input logic [6:0] a, input int n);
      logic [6:0] ad = a;
      open_win();
      send_byte({1'b1, a});
      check(sdo_oe, "R6", "oe after read command", int'(sdo_oe), 1);
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(int'(ad) < NR ? model[ad] : 8'h00);
         ad = ad + 7'd1;
      end
      for (int k = 0; k < n; k++) send_byte(8'h00);
      close_win();
      check(exp_q.size() == 0, "R7", "bytes left unread", exp_q.size(), 0);
      check(!sdo_oe && !sdo, "R8", "line released after window", int'({sdo_oe, sdo}), 0);
   endtask

   // monitor: assembles bytes at host sampling edges and compares them with the queue
   always @(negedge sclk) begin
      if (sel && sdo_oe) begin
         mon_sh = {mon_sh[6:0], sdo};
         mon_n++;
         if (mon_n == 8) begin
            mon_n = 0;
            if (exp_q.size() == 0) check(1'b0, "R6", "unexpected read byte", int'(mon_sh), 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               check(mon_sh == e, "R6", "read byte (R7 burst order)", int'(mon_sh), int'(e));
            end
         end
      end
   end
   always @(negedge sel) mon_n = 0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; sel = 1'b0; sclk = 1'b0; sdi = 1'b0;
      foreach (model[i]) model[i] = 8'h00;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      // R1: reset state
      check_bank("R1");
      check(!sdo_oe && !sdo, "R1", "line idle after reset", int'({sdo_oe, sdo}), 0);

      // R2, R3: single byte write
      write_burst(7'd2, '{8'hA5}, "R2");
      // R4: burst write with auto-increment
      write_burst(7'd4, '{8'h11, 8'h22, 8'h33}, "R4");
      // R6, R7: read back a burst
      read_burst(7'd4, 3);
      read_burst(7'd2, 1);

      // R5: partial data byte abandoned
      open_win();
      send_byte(8'h01);
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      close_win();
      check_bank("R5");
      // R5: partial command byte abandoned, next window framed afresh
      open_win();
      for (int i = 0; i < 3; i++) send_bit(1'b1);
      close_win();
      write_burst(7'd3, '{8'h3C}, "R5");

      // R9: activity while select is low
      for (int i = 0; i < 12; i++) send_bit(logic'(i % 3 == 0));
      check_bank("R9");
      check(!sdo_oe, "R9", "oe with select low", int'(sdo_oe), 0);

      // R10, R11: write at 127 dropped, wrap to register 0
      write_burst(7'd127, '{8'hEE, 8'h77}, "R10");
      check(regs[7:0] == 8'h77, "R11", "wrap to reg0", int'(regs[7:0]), 'h77);
      // R10, R11: read beyond range returns zero, then wraps
      read_burst(7'd127, 2);
      read_burst(7'd6, 3);

      done = 1;
      summary();
      $finish;
   end
endmodule